// File: doc/BRIEF.md
# Programmable Bit-Rate Divider

This block turns a fast input clock into the bit-rate timing for a serial transmitter and receiver. It is a down-counter whose modulus N is set by software. N is loaded as two byte-wide writes. A write of the upper byte is only staged. A write of the lower byte joins it to the staged upper byte and commits the full value. The block produces a one-cycle `tick` every N input clocks. It can also produce a square wave `sq_clk` that inverts on every tick.

A commit reloads the counter in the same clock edge. A newly programmed rate therefore starts at once, and a long count left over from an old or unset value never has to run out first. A committed value of 0 or 1 halts the generator: both outputs stay low until a value of 2 or more is committed. After reset the staged byte and the divisor are zero, so the block comes up halted. The largest usable divisor is 65535.

Top module: `baud_divider`

## Requirements
- R1: The divisor N is 16 bits wide. Asserting `wr_hi` stages `wr_data` as bits 15:8. Asserting `wr_lo` commits N = {staged byte, `wr_data`}, with `wr_data` as bits 7:0.
- R2: A `wr_hi` without `wr_lo` changes neither the running count nor the outputs. The tick spacing continues unchanged.
- R3: A `wr_lo` that commits N ≥ 2 restarts counting on that clock edge, whatever the old count was. The first `tick` is high in the cycle that begins N−1 edges after the committing edge.
- R4: While running, `tick` is high for exactly one cycle out of every N.
- R5: Committing N = 0 or N = 1 halts the generator. `tick` and `sq_clk` stay low until a later commit of N ≥ 2.
- R6: After reset the generator is halted, the staged byte is zero and both outputs are low. No tick appears until a commit.
- R7: `sq_clk` goes low on every commit and inverts on the clock edge that ends each tick cycle, giving a period of 2N input clocks.
- R8: When `wr_hi` and `wr_lo` are asserted in the same cycle, the commit uses the byte staged before that cycle. `wr_data` becomes the staged byte for later commits.
- R9: The largest divisor, 65535, runs with a tick spacing of 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_hi | input | 1 | Stage `wr_data` as divisor bits 15:8 |
| wr_lo | input | 1 | Commit divisor with `wr_data` as bits 7:0 and reload |
| wr_data | input | 8 | Byte being written |
| tick | output | 1 | One-cycle pulse every N clocks |
| sq_clk | output | 1 | Square wave inverted on each tick |

## Verification
The case hardest to reach from the ports is a commit that arrives partway through a long count. That is the only case that shows whether the reload is immediate or waits for terminal count. The stimulus commits N = 1000, waits ten cycles, restages the upper byte and commits N = 3. The scoreboard drops every tick still queued for the old rate and expects the new first tick exactly two edges after the commit. A second hard case writes both strobes in one cycle. It checks that the committed value uses the older staged byte, then commits again using only the low byte to show which byte was kept.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

   typedef enum logic {
      GEN_HALT = 1'b0,
      GEN_RUN  = 1'b1
   } gen_state_e;

   localparam int unsigned MIN_RUN_DIV = 2;

endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned DIV_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] stage_hi,
   output logic              commit,
   output logic [DIV_W-1:0]  commit_val,
   output logic [DIV_W-1:0]  div_q
);

   // the commit always pairs with the byte staged before this cycle
   assign commit     = wr_lo;
   assign commit_val = {stage_hi, wr_data};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_hi <= '0;
         div_q    <= '0;
      end else begin
         if (wr_hi) stage_hi <= wr_data;
         if (wr_lo) div_q    <= commit_val;
      end
   end

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter
   import baud_div_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count,
   output logic             running,
   output logic             tick
);

   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] MIN_DIV = CNT_W'(MIN_RUN_DIV);

   gen_state_e state_q;
   logic       load_ok;
   logic       at_zero;

   assign load_ok = (load_val >= MIN_DIV);
   assign at_zero = (count == '0);
   assign running = (state_q == GEN_RUN);
   assign tick    = running && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= GEN_HALT;
         count   <= '0;
      end else if (load) begin
         if (load_ok) begin
            state_q <= GEN_RUN;
            count   <= load_val - ONE;
         end else begin
            state_q <= GEN_HALT;
            count   <= '0;
         end
      end else if (running) begin
         if (at_zero) count <= reload_val - ONE;
         else         count <= count - ONE;
      end
   end

endmodule

// File: rtl/baud_div_square.sv
module baud_div_square (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic sq
);

   always_ff @(posedge clk) begin
      if (!rst_n)      sq <= 1'b0;
      else if (clear)  sq <= 1'b0;
      else if (tick)   sq <= ~sq;
   end

endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned CNT_W     = 16,
   parameter bit          SQUARE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hi,
   input  logic              wr_lo,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              tick,
   output logic              sq_clk
);

   if (BYTE_W < 1) begin : g_bad_byte
      $error("baud_divider: BYTE_W must be at least 1");
   end
   if (CNT_W != 2 * BYTE_W) begin : g_bad_width
      $error("baud_divider: CNT_W must equal twice BYTE_W");
   end

   logic [BYTE_W-1:0] hi_w;
   logic              commit_w;
   logic [CNT_W-1:0]  commit_val_w;
   logic [CNT_W-1:0]  div_w;
   logic [CNT_W-1:0]  count_w;
   logic              run_w;

   baud_div_regs #(
      .BYTE_W (BYTE_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hi      (wr_hi),
      .wr_lo      (wr_lo),
      .wr_data    (wr_data),
      .stage_hi   (hi_w),
      .commit     (commit_w),
      .commit_val (commit_val_w),
      .div_q      (div_w)
   );

   baud_div_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (commit_w),
      .load_val   (commit_val_w),
      .reload_val (div_w),
      .count      (count_w),
      .running    (run_w),
      .tick       (tick)
   );

   if (SQUARE_EN) begin : g_square
      baud_div_square u_sq (
         .clk   (clk),
         .rst_n (rst_n),
         .clear (commit_w),
         .tick  (tick),
         .sq    (sq_clk)
      );
   end else begin : g_no_square
      assign sq_clk = 1'b0;
   end

endmodule

// File: rtl/baud_divider_chk.sv
module baud_divider_chk #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_hi,
   input logic              wr_lo,
   input logic [BYTE_W-1:0] wr_data,
   input logic              tick,
   input logic              sq_clk,
   input logic [BYTE_W-1:0] hi_q,
   input logic [CNT_W-1:0]  count,
   input logic              running
);

   // R3
   load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && ({hi_q, wr_data} >= CNT_W'(2)))
         |=> (running && count == $past({hi_q, wr_data}) - CNT_W'(1)));

   // R5
   halt_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && ({hi_q, wr_data} < CNT_W'(2))) |=> (!tick && !sq_clk && !running));

   // R5
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !wr_lo) |=> (!running && !tick && $stable(count)));

   // R4
   tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R2
   hi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo && running && count != '0) |=> (count == $past(count) - CNT_W'(1)));

   // R7
   sq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_lo) |=> $stable(sq_clk));

   // R7
   sq_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_lo) |=> (sq_clk != $past(sq_clk)));

   // R8
   stage_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (hi_q == $past(wr_data)));

endmodule

bind baud_divider baud_divider_chk #(
   .BYTE_W (BYTE_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_hi   (wr_hi),
   .wr_lo   (wr_lo),
   .wr_data (wr_data),
   .tick    (tick),
   .sq_clk  (sq_clk),
   .hi_q    (hi_w),
   .count   (count_w),
   .running (run_w)
);

// File: tb/baud_divider_bench.sv
module baud_divider_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_hi = 1'b0;
   logic       wr_lo = 1'b0;
   logic [7:0] wr_data = '0;
   logic       tick;
   logic       sq_clk;

   int    cyc = 0;
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    mon_on = 1'b0;
   bit    exp_sq = 1'b0;
   bit    finished = 1'b0;
   logic [7:0] model_hi = '0;
   string cur_req = "R6";
   int    tick_q[$];

   always #2 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   baud_divider u_baud_divider (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (wr_hi),
      .wr_lo   (wr_lo),
      .wr_data (wr_data),
      .tick    (tick),
      .sq_clk  (sq_clk)
   );

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // monitor: pops the expected tick cycles and tracks the square wave
   always @(negedge clk) begin
      if (mon_on) begin
         bit due;
         due = (tick_q.size() > 0) && (tick_q[0] == cyc);
         n_cmp++;
         if (tick !== due) begin
            n_bad++;
            $display("FAIL %s tick at cycle %0d: actual %0b expected %0b",
                     cur_req, cyc, tick, due);
         end
         if (due) void'(tick_q.pop_front());
         n_cmp++;
         if (sq_clk !== exp_sq) begin
            n_bad++;
            $display("FAIL R7 sq_clk at cycle %0d: actual %0b expected %0b",
                     cyc, sq_clk, exp_sq);
         end
         if (due) exp_sq = ~exp_sq;
      end
   end

   // driver: applies one write and queues the tick cycles it implies
   task automatic wr(input bit do_hi, input bit do_lo, input logic [7:0] b,
                     input int win, input string req);
      int n;
      int e;
      cur_req = req;
      n = int'({model_hi, b});
      if (do_hi) model_hi = b;
      wr_hi = do_hi;
      wr_lo = do_lo;
      wr_data = b;
      @(posedge clk);
      #1;
      e = cyc;
      wr_hi = 1'b0;
      wr_lo = 1'b0;
      if (do_lo) begin
         while (tick_q.size() > 0 && tick_q[$] >= e) void'(tick_q.pop_back());
         exp_sq = 1'b0;
         if (n >= 2) begin
            for (int t = e + n - 1; t <= e + win + 64; t += n) tick_q.push_back(t);
         end
      end
      repeat (win) @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic idle(input int k, input string req);
      cur_req = req;
      repeat (k) @(negedge clk);
      #1;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R6: reset state, sampled away from the edge
      n_cmp++;
      if (tick !== 1'b0 || sq_clk !== 1'b0) begin
         n_bad++;
         $display("FAIL R6 after reset: actual tick=%0b sq=%0b expected 0/0", tick, sq_clk);
      end
      mon_on = 1'b1;
      idle(20, "R6");

      // R1 R3 R4 R7: N = 5
      wr(1'b1, 1'b0, 8'h00, 0, "R1");
      wr(1'b0, 1'b1, 8'h05, 40, "R4");

      // R2: stage upper byte while N=5 runs, spacing unchanged
      wr(1'b1, 1'b0, 8'h01, 0, "R2");
      idle(12, "R2");
      // R1: commit 0x0102 = 258
      wr(1'b0, 1'b1, 8'h02, 600, "R1");

      // R4: smallest running divisor
      wr(1'b1, 1'b0, 8'h00, 0, "R1");
      wr(1'b0, 1'b1, 8'h02, 20, "R4");

      // R5: halt with 1 and with 0
      wr(1'b0, 1'b1, 8'h01, 30, "R5");
      wr(1'b0, 1'b1, 8'h00, 30, "R5");

      // R3: mid-count commit restarts at once
      wr(1'b1, 1'b0, 8'h03, 0, "R1");
      wr(1'b0, 1'b1, 8'hE8, 10, "R3");
      wr(1'b1, 1'b0, 8'h00, 0, "R3");
      wr(1'b0, 1'b1, 8'h03, 30, "R3");

      // R8: both strobes, staged byte is 0x00 -> N = 4, then 0x0400
      wr(1'b1, 1'b1, 8'h04, 30, "R8");
      wr(1'b0, 1'b1, 8'h00, 1100, "R8");

      // R9: largest divisor 0xFFFF
      wr(1'b1, 1'b0, 8'hFF, 0, "R9");
      wr(1'b0, 1'b1, 8'hFF, 65600, "R9");

      // R5: halt again after running
      wr(1'b1, 1'b0, 8'h00, 0, "R5");
      wr(1'b0, 1'b1, 8'h01, 50, "R5");

      mon_on = 1'b0;
      n_cmp++;
      if (tick_q.size() != 0) begin
         n_bad++;
         $display("FAIL R4 leftover expected ticks: actual %0d expected 0", tick_q.size());
      end
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule